// File: doc/BRIEF.md
# Conditional Move Decode-Execute Unit

This block decodes and executes a small family of RV32 conditional-move instructions in one registered stage. Three encodings are recognised. A 32-bit register form compares the first source against a second source register. A 32-bit immediate form compares the first source against a 5-bit constant held in the second-source field. A 16-bit compressed form moves a source into its destination only when the destination currently holds zero.

In the 32-bit forms, a true condition writes the third source register's value into the destination. A false condition suppresses the write, so the destination keeps its old value.

The surrounding pipeline presents one instruction word with a valid flag, together with the register values it has already read. The block answers one clock later with a destination index, the value to write, a write enable and an illegal-instruction flag. Encodings that are malformed, that use a reserved condition code, or that name register zero where this is not allowed are reported as illegal and never write.

Top module: `cmov_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `out_valid`, `out_we`, `out_illegal`, `out_rd_idx` and `out_wdata` to zero.
- R2: Every output is registered and reflects the input presented before the preceding clock edge. After an edge where `in_valid` was low, `out_valid`, `out_we` and `out_illegal` are low. After an edge where `in_valid` was high, `out_valid` is high.
- R3: A word with `in_instr[1:0]` = 11 is a 32-bit form. It needs major opcode `in_instr[6:0]` = 1011011. The destination is in [11:7], the first source in [19:15], the second source or immediate in [24:20], the form selector in [26:25], the condition in [14:12] and the third source in [31:27]. Form selector 00 is the register form: it compares `op_rs1` with `op_rs2`. On a true condition it drives `out_we`=1, `out_rd_idx` = bits [11:7] and `out_wdata` = `op_rs3`.
- R4: The condition codes are: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal.
- R5: Form selector 10 is the immediate form. It compares `op_rs1` with bits [24:20]. Those bits are sign-extended for codes 000, 001, 100 and 101, and zero-extended for codes 110 and 111.
- R6: On a legal 32-bit form whose condition is false, `out_we`=0, `out_illegal`=0, `out_rd_idx` is still the destination field and `out_wdata` is still `op_rs3`.
- R7: A 32-bit form is illegal if any of these fields is zero: destination, first source, third source, or the second-source field in the register form. A zero immediate in the immediate form is legal.
- R8: A 32-bit word is illegal if its opcode is not 1011011, its form selector is 01 or 11, or its condition code is 010 or 011. An illegal result drives `out_illegal`=1, `out_we`=0, `out_rd_idx`=0 and `out_wdata`=0.
- R9: The compressed form needs these fields: [1:0]=10, [15:13]=101, [12:10]=011 and [6:5]=00. Bits [31:16] are ignored. Its destination is register 8 plus [4:2]. `op_rs1` holds the source named by [9:7] and `op_rd` holds the destination's current value. If `op_rd` is zero it drives `out_we`=1; otherwise `out_we`=0. In both cases `out_wdata` = `op_rs1` and `out_rd_idx` = 8 + [4:2].
- R10: A word with [1:0] other than 11 that fails any compressed field test is illegal, with the outputs of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_instr | input | 32 | Instruction word (compressed forms in the low 16 bits) |
| op_rs1 | input | XLEN | Value of the first source register |
| op_rs2 | input | XLEN | Value of the second source register (register form) |
| op_rs3 | input | XLEN | Value of the third source register (32-bit forms) |
| op_rd | input | XLEN | Current value of the destination (compressed form) |
| out_valid | output | 1 | Result belongs to a valid instruction |
| out_illegal | output | 1 | Instruction word was not a legal encoding |
| out_rd_idx | output | 5 | Destination register index |
| out_wdata | output | XLEN | Value to write |
| out_we | output | 1 | Write enable, low when the condition is false |

## Verification
The register form is swept over every condition code with pairs drawn from a set of boundary values: zero, one, all ones, the most positive and most negative values, and values near the 5-bit limits. This set separates signed from unsigned ordering and equality from ordering.

The immediate form runs every 5-bit constant against the same operands under all eight codes. This exposes a wrong extension at 15/16 and at -16/31, and it confirms that the reserved codes are rejected.

The compressed form is driven over all destination and source pairs with zero and non-zero destination values. Each of its fixed bits and each 32-bit opcode bit is then flipped singly to show the encoding is rejected. Separate cases with register zero in each field show which fields are checked.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

    localparam int ILEN   = 32;
    localparam int IMM_W  = 5;
    localparam int REG_W  = 5;
    localparam int CREG_W = 3;

    localparam logic [6:0] OPC_CMOV = 7'b1011011;
    localparam logic [1:0] SEL_REG  = 2'b00;
    localparam logic [1:0] SEL_IMM  = 2'b10;

    // compressed fixed fields
    localparam logic [1:0] C_QUAD   = 2'b10;
    localparam logic [2:0] C_TOP    = 3'b101;
    localparam logic [2:0] C_MID    = 3'b011;
    localparam logic [1:0] C_LOW    = 2'b00;

    typedef enum logic [2:0] {
        COND_EQ  = 3'b000,
        COND_NE  = 3'b001,
        COND_LT  = 3'b100,
        COND_GE  = 3'b101,
        COND_LTU = 3'b110,
        COND_GEU = 3'b111
    } cond_e;

    typedef enum logic [1:0] {
        FORM_REG,
        FORM_IMM,
        FORM_CZ,
        FORM_NONE
    } form_e;

    typedef struct packed {
        logic             legal;
        form_e            form;
        cond_e            cond;
        logic [REG_W-1:0] rd;
        logic [IMM_W-1:0] imm;
    } dec_t;

    function automatic logic cond_is_unsigned(cond_e c);
        return (c == COND_LTU) || (c == COND_GEU);
    endfunction

    function automatic logic code_is_defined(logic [2:0] code);
        return (code != 3'b010) && (code != 3'b011);
    endfunction

    function automatic logic [REG_W-1:0] creg_to_reg(logic [CREG_W-1:0] r);
        return {2'b01, r};
    endfunction

endpackage

// File: rtl/cmov_decode.sv
module cmov_decode
    import cmov_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);

    logic             wide;
    logic [6:0]       opc;
    logic [1:0]       sel;
    logic [2:0]       code;
    logic [REG_W-1:0] f_rd, f_rs1, f_rs2, f_rs3;
    logic             ok_opc, ok_sel, ok_code, ok_regs, ok_wide, ok_cz;

    assign wide  = (instr[1:0] == 2'b11);
    assign opc   = instr[6:0];
    assign f_rd  = instr[11:7];
    assign code  = instr[14:12];
    assign f_rs1 = instr[19:15];
    assign f_rs2 = instr[24:20];
    assign sel   = instr[26:25];
    assign f_rs3 = instr[31:27];

    assign ok_opc  = (opc == OPC_CMOV);
    assign ok_sel  = (sel == SEL_REG) || (sel == SEL_IMM);
    assign ok_code = code_is_defined(code);
    assign ok_regs = (f_rd != '0) && (f_rs1 != '0) && (f_rs3 != '0) &&
                     ((sel == SEL_IMM) || (f_rs2 != '0));
    assign ok_wide = ok_opc && ok_sel && ok_code && ok_regs;

    assign ok_cz = (instr[1:0] == C_QUAD) && (instr[15:13] == C_TOP) &&
                   (instr[12:10] == C_MID) && (instr[6:5] == C_LOW);

    always_comb begin
        dec.legal = 1'b0;
        dec.form  = FORM_NONE;
        dec.cond  = COND_EQ;
        dec.rd    = '0;
        dec.imm   = '0;
        if (wide) begin
            if (ok_wide) begin
                dec.legal = 1'b1;
                dec.form  = (sel == SEL_IMM) ? FORM_IMM : FORM_REG;
                dec.cond  = cond_e'(code);
                dec.rd    = f_rd;
                dec.imm   = f_rs2;
            end
        end else if (ok_cz) begin
            dec.legal = 1'b1;
            dec.form  = FORM_CZ;
            dec.cond  = COND_EQ;
            dec.rd    = creg_to_reg(instr[4:2]);
        end
    end

endmodule

// File: rtl/cmov_compare.sv
module cmov_compare
    import cmov_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e            cond,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  lhs,
    input  logic [XLEN-1:0]  rhs_reg,
    output logic             hit
);

    localparam int PAD = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rhs;
    logic            eq, lt_s, lt_u;

    assign imm_ext = cond_is_unsigned(cond) ? {{PAD{1'b0}}, imm}
                                            : {{PAD{imm[IMM_W-1]}}, imm};
    assign rhs  = use_imm ? imm_ext : rhs_reg;
    assign eq   = (lhs == rhs);
    assign lt_s = ($signed(lhs) < $signed(rhs));
    assign lt_u = (lhs < rhs);

    always_comb begin
        unique case (cond)
            COND_EQ:  hit = eq;
            COND_NE:  hit = !eq;
            COND_LT:  hit = lt_s;
            COND_GE:  hit = !lt_s;
            COND_LTU: hit = lt_u;
            COND_GEU: hit = !lt_u;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
    import cmov_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ILEN-1:0]  in_instr,
    input  logic [XLEN-1:0]  op_rs1,
    input  logic [XLEN-1:0]  op_rs2,
    input  logic [XLEN-1:0]  op_rs3,
    input  logic [XLEN-1:0]  op_rd,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [REG_W-1:0] out_rd_idx,
    output logic [XLEN-1:0]  out_wdata,
    output logic             out_we
);

    dec_t            dec;
    logic            is_cz;
    logic [XLEN-1:0] cmp_lhs, cmp_rhs, move_val;
    logic            hit;

    cmov_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    // compressed zero test reuses the comparator as "op_rd == 0"
    assign is_cz    = (dec.form == FORM_CZ);
    assign cmp_lhs  = is_cz ? op_rd : op_rs1;
    assign cmp_rhs  = is_cz ? '0    : op_rs2;
    assign move_val = is_cz ? op_rs1 : op_rs3;

    cmov_compare #(.XLEN(XLEN)) u_cmp (
        .cond    (dec.cond),
        .use_imm (dec.form == FORM_IMM),
        .imm     (dec.imm),
        .lhs     (cmp_lhs),
        .rhs_reg (cmp_rhs),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_we      <= 1'b0;
            out_rd_idx  <= '0;
            out_wdata   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= !dec.legal;
                out_we      <= dec.legal && hit;
                out_rd_idx  <= dec.legal ? dec.rd : '0;
                out_wdata   <= dec.legal ? move_val : '0;
            end else begin
                out_illegal <= 1'b0;
                out_we      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmov_unit_chk.sv
module cmov_unit_chk
    import cmov_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [ILEN-1:0]  in_instr,
    input logic [XLEN-1:0]  op_rd,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [REG_W-1:0] out_rd_idx,
    input logic             out_we
);

    // R2
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_we |-> out_valid);

    // R8
    illegal_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_we && out_valid));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_we && !out_illegal));

    // R2
    issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    cz_nonzero_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[1:0] != 2'b11 && op_rd != '0) |=> !out_we);

    // R7
    wide_x0_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[1:0] == 2'b11 && in_instr[11:7] == 5'd0) |=> out_illegal);

    // R7
    write_never_x0_chk: assert property (@(posedge clk) disable iff (rst)
        out_we |-> (out_rd_idx != 5'd0));

    // R9
    cz_dest_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[1:0] == 2'b10 && in_instr[15:10] == 6'b101011 &&
         in_instr[6:5] == 2'b00) |=> (out_rd_idx[4:3] == 2'b01 && !out_illegal));

endmodule

bind cmov_unit cmov_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .op_rd       (op_rd),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_rd_idx  (out_rd_idx),
    .out_we      (out_we)
);

// File: tb/sim_cmov_unit.sv
`timescale 1ns/1ps
module sim_cmov_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] op_rs1 = '0, op_rs2 = '0, op_rs3 = '0, op_rd = '0;
    logic        out_valid, out_illegal, out_we;
    logic [4:0]  out_rd_idx;
    logic [31:0] out_wdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cmov_unit #(.XLEN(32)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .op_rs1(op_rs1), .op_rs2(op_rs2), .op_rs3(op_rs3), .op_rd(op_rd),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_rd_idx(out_rd_idx),
        .out_wdata(out_wdata), .out_we(out_we)
    );

    typedef struct {
        logic        we;
        logic        ill;
        logic [4:0]  rd;
        logic [31:0] wd;
    } exp_t;

    logic [31:0] pts [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'd15, 32'd16, 32'hFFFF_FFF0, 32'd31, 32'hFFFF_FFEF};

    function automatic logic [31:0] enc32(logic [1:0] f2, logic [2:0] f3, logic [4:0] rd,
                                          logic [4:0] s1, logic [4:0] s2, logic [4:0] s3);
        return {s3, f2, s2, s1, f3, rd, 7'b1011011};
    endfunction

    function automatic logic [31:0] enc16(logic [15:0] hi, logic [2:0] rdp, logic [2:0] s1p);
        return {hi, 3'b101, 3'b011, s1p, 2'b00, rdp, 2'b10};
    endfunction

    // expectation built from the requirement text
    function automatic exp_t model(logic [31:0] w, logic [31:0] a, logic [31:0] b,
                                   logic [31:0] c, logic [31:0] d);
        exp_t e;
        logic ok, t;
        logic [31:0] r;
        logic [2:0] f3;
        logic [1:0] f2;
        e.we = 0; e.ill = 1; e.rd = 0; e.wd = 0;
        if (w[1:0] == 2'b11) begin
            f3 = w[14:12]; f2 = w[26:25];
            ok = (w[6:0] == 7'b1011011) && (f2 == 2'b00 || f2 == 2'b10) &&
                 f3 != 3'd2 && f3 != 3'd3 && w[11:7] != 0 && w[19:15] != 0 &&
                 w[31:27] != 0 && (f2 == 2'b10 || w[24:20] != 0);
            if (f2 == 2'b00) r = b;
            else if (f3 >= 3'd6) r = {27'd0, w[24:20]};
            else r = {{27{w[24]}}, w[24:20]};
            case (f3)
                3'd0: t = (a == r);
                3'd1: t = (a != r);
                3'd4: t = ($signed(a) < $signed(r));
                3'd5: t = !($signed(a) < $signed(r));
                3'd6: t = (a < r);
                default: t = !(a < r);
            endcase
            if (ok) begin e.ill = 0; e.we = t; e.rd = w[11:7]; e.wd = c; end
        end else begin
            ok = (w[1:0] == 2'b10) && (w[15:13] == 3'b101) && (w[12:10] == 3'b011) &&
                 (w[6:5] == 2'b00);
            if (ok) begin e.ill = 0; e.we = (d == 0); e.rd = 5'd8 + w[4:2]; e.wd = a; end
        end
        return e;
    endfunction

    task automatic run(input logic v, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c, input logic [31:0] d,
                       input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_instr = w; op_rs1 = a; op_rs2 = b; op_rs3 = c; op_rd = d;
        e = model(w, a, b, c, d);
        @(posedge clk);
        #1;
        total++;
        if (v) begin
            if (out_valid !== 1'b1 || out_we !== e.we || out_illegal !== e.ill ||
                out_rd_idx !== e.rd || out_wdata !== e.wd) begin
                bad++;
                $display("FAIL %s instr=%h: got v=%b we=%b ill=%b rd=%0d wd=%h exp v=1 we=%b ill=%b rd=%0d wd=%h",
                         tag, w, out_valid, out_we, out_illegal, out_rd_idx, out_wdata,
                         e.we, e.ill, e.rd, e.wd);
            end
        end else if (out_valid !== 1'b0 || out_we !== 1'b0 || out_illegal !== 1'b0) begin
            bad++;
            $display("FAIL %s idle: got v=%b we=%b ill=%b exp 0 0 0", tag,
                     out_valid, out_we, out_illegal);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (out_valid !== 0 || out_we !== 0 || out_illegal !== 0 || out_rd_idx !== 0 ||
            out_wdata !== 0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b we=%b ill=%b rd=%0d wd=%h exp all zero",
                     out_valid, out_we, out_illegal, out_rd_idx, out_wdata);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2: idle cycle
        run(0, enc32(2'b00, 3'd0, 5'd9, 5'd10, 5'd11, 5'd12), 1, 1, 7, 0, "R2");
        // R3: basic register-form write
        run(1, enc32(2'b00, 3'd0, 5'd9, 5'd10, 5'd11, 5'd12), 32'h55, 32'h55, 32'hCAFE, 0, "R3");

        // R4 / R6: register form sweep
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    if (f != 2 && f != 3)
                        run(1, enc32(2'b00, 3'(f), 5'd9, 5'd10, 5'd11, 5'd12), pts[i], pts[j],
                            32'hC0DE_0000 + 32'(i * 16 + j), 0,
                            (model(enc32(2'b00, 3'(f), 5'd9, 5'd10, 5'd11, 5'd12), pts[i], pts[j], 0, 0).we)
                            ? "R4" : "R6");

        // R5 / R8: immediate form, every constant, every code
        for (int f = 0; f < 8; f++)
            for (int k = 0; k < 32; k++)
                for (int i = 0; i < 10; i++)
                    run(1, enc32(2'b10, 3'(f), 5'd3, 5'd4, 5'(k), 5'd5), pts[i], 32'hDEAD,
                        32'hBEEF_0000 + 32'(k), 0, (f == 2 || f == 3) ? "R8" : "R5");

        // R5 extension boundaries
        run(1, enc32(2'b10, 3'd0, 5'd3, 5'd4, 5'd16, 5'd5), 32'hFFFF_FFF0, 0, 32'h11, 0, "R5");
        run(1, enc32(2'b10, 3'd6, 5'd3, 5'd4, 5'd16, 5'd5), 32'd15, 0, 32'h22, 0, "R5");

        // R7: register zero in each field
        run(1, enc32(2'b00, 3'd0, 5'd0, 5'd10, 5'd11, 5'd12), 1, 1, 2, 0, "R7");
        run(1, enc32(2'b00, 3'd0, 5'd9, 5'd0, 5'd11, 5'd12), 1, 1, 2, 0, "R7");
        run(1, enc32(2'b00, 3'd0, 5'd9, 5'd10, 5'd0, 5'd12), 1, 1, 2, 0, "R7");
        run(1, enc32(2'b00, 3'd0, 5'd9, 5'd10, 5'd11, 5'd0), 1, 1, 2, 0, "R7");
        run(1, enc32(2'b10, 3'd0, 5'd9, 5'd10, 5'd0, 5'd12), 0, 9, 32'h77, 0, "R7");

        // R8: bad opcode bits and form selectors
        for (int b = 0; b < 7; b++)
            run(1, enc32(2'b00, 3'd0, 5'd9, 5'd10, 5'd11, 5'd12) ^ (32'd1 << b), 1, 1, 3, 0, "R8");
        run(1, enc32(2'b01, 3'd0, 5'd9, 5'd10, 5'd11, 5'd12), 1, 1, 3, 0, "R8");
        run(1, enc32(2'b11, 3'd1, 5'd9, 5'd10, 5'd11, 5'd12), 1, 2, 3, 0, "R8");
        run(1, enc32(2'b00, 3'd2, 5'd9, 5'd10, 5'd11, 5'd12), 1, 2, 3, 0, "R8");

        // R9: compressed, all register pairs, zero and non-zero destination
        for (int rdp = 0; rdp < 8; rdp++)
            for (int s = 0; s < 8; s++) begin
                run(1, enc16(16'hA5A5, 3'(rdp), 3'(s)), 32'h1000 + 32'(s), 0, 0, 0, "R9");
                run(1, enc16(16'h5A5A, 3'(rdp), 3'(s)), 32'h2000 + 32'(s), 0, 0, 1, "R9");
                run(1, enc16(16'h0000, 3'(rdp), 3'(s)), 32'h3000, 0, 0, 32'h8000_0000, "R9");
            end

        // R10: each fixed compressed bit flipped
        for (int b = 0; b < 16; b++)
            if (b == 1 || b == 5 || b == 6 || b >= 10)
                run(1, enc16(16'h0, 3'd1, 3'd2) ^ (32'd1 << b), 32'h44, 0, 0, 0, "R10");
        run(1, enc16(16'h0, 3'd1, 3'd2) ^ 32'd1, 32'h44, 0, 0, 0, "R10");

        run(0, 32'h0, 0, 0, 0, 0, "R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule